// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block sits beside a small microcontroller core and manages its low-power states. When the core issues a sleep request, the controller reads a 3-bit mode select and enters one of three sleep modes: Idle, ADC noise reduction, or Power-down. In each mode it turns off a mode-specific set of clock-domain enables. While asleep, it watches a vector of pending wake requests. Only the sources allowed for the current mode may end the sleep.

A control-register write port gives software a brown-out detector sleep-disable bit. The bit is protected by a timed arm-then-write sequence. If the bit is set, the detector enable drops for the duration of a Power-down sleep. When that happens, the wake-up is stretched by a settling delay derived from the clock frequency, so the detector is running again before the CPU resumes. Otherwise the wake-up takes a short fixed delay.

The controller also issues a one-cycle ADC conversion start pulse when it enters Idle or ADC noise reduction with the ADC enabled.

Top module: `slp_pwr_ctl`

## Requirements
- R1: After reset all six enables (cpu, flash, io, adc, async, osc) are 1, `bod_en` is 1, `cpu_run` is 1, `adc_start` is 0 and the detector-off bit is 0.
- R2: A `mode_sel` of 000, or any reserved value 011 to 111, selects Idle: while asleep cpu and flash enables are 0, and io, adc, async and osc enables are 1.
- R3: A `mode_sel` of 001 selects ADC noise reduction: while asleep cpu, flash and io enables are 0, and adc, async and osc enables are 1.
- R4: A `mode_sel` of 010 selects Power-down: while asleep all six enables are 0.
- R5: The `wake_vec` bit indices are: 0 ADC done, 1 external reset, 2 watchdog reset, 3 brown-out reset, 4 LCD, 5 serial start condition, 6 asynchronous timer, 7 memory ready, 8 level interrupt 0, 9 pin change, 10 timer overflow, 11 serial transmit complete. Which bits wake the block depends on the mode:
  - Idle: any bit.
  - ADC noise reduction: bits 0 to 9.
  - Power-down: bits 1, 2, 3, 5, 8 and 9.
  - Any other bit leaves the block asleep with its gating unchanged.
- R6: `adc_start` is high for exactly the one cycle after sleep entry when `adc_on` is 1 and the mode is Idle or ADC noise reduction. It stays low for Power-down, and it stays low whenever `adc_on` is 0.
- R7: The detector-off bit is bit 6 of `ctl_wdata`. A write with bits 6 and 5 both 1 arms a window. A write with bit 5 = 0 on any of the next 4 clock edges loads bit 6 and closes the window. A write outside a window, or one made later than those 4 edges, leaves the bit unchanged.
- R8: `bod_en` is 0 exactly while asleep in Power-down entered with the detector-off bit set. It is 1 in all other modes and states, including from the first wake cycle onward.
- R9: A qualifying wake moves the block to a wake phase. `cpu_run` rises after LONG edges if the detector was off during the sleep, and after SHORT edges otherwise. LONG is CLK_HZ × SETTLE_US / 10^6, rounded up; it is 60 at the defaults. SHORT is 4 at the defaults. During the wake phase cpu and flash enables stay 0 and the other four are 1.
- R10: A sleep request made while a wake source that qualifies for the requested mode is pending is refused. `cpu_run` stays 1, no enable drops, and no `adc_start` is issued.
- R11: `sleep_req` has no effect while asleep or waking: the mode latched at entry keeps its gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| mode_sel | input | 3 | Sleep mode select |
| adc_on | input | 1 | ADC is enabled |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| wake_vec | input | 12 | Pending wake requests, indexed as in R5 |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous clock enable |
| osc_en | output | 1 | External oscillator enable |
| bod_en | output | 1 | Brown-out detector enable |
| adc_start | output | 1 | ADC conversion start pulse |
| cpu_run | output | 1 | CPU may execute |

## Verification
The bench targets the edges of the timed write window. A write on the fourth edge after arming must take effect and one on the fifth must not. An off-by-one window counter would flip one of these two outcomes, which the bench sees as `bod_en` staying high, or dropping, in Power-down.

The bench also measures the exact number of edges from wake to `cpu_run` for both the short and the detector-settling delays. A counter loaded with the full count instead of count minus one adds a cycle to both.

Wake sources that do not qualify for the current mode are applied. A design with a wrong mask would resume early instead of staying asleep. A pending wake at request time must leave the core running. A controller that gated first would drop the enables for a cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int NSRC = 12;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ADCNR = 2'd1,
    M_PDOWN = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    S_RUN   = 2'd0,
    S_SLEEP = 2'd1,
    S_WAKE  = 2'd2
  } state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic async_ck;
    logic osc;
  } dom_t;

  localparam dom_t DOM_ALL  = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, async_ck: 1'b1, osc: 1'b1};
  localparam dom_t DOM_WAKE = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, async_ck: 1'b1, osc: 1'b1};

  // 010 is power-down, 001 ADC noise reduction, all else idle
  function automatic mode_e decode_mode(input logic [2:0] sel);
    case (sel)
      3'b001:  return M_ADCNR;
      3'b010:  return M_PDOWN;
      default: return M_IDLE;
    endcase
  endfunction

  function automatic dom_t gate_set(input mode_e m);
    dom_t d;
    d = DOM_ALL;
    d.cpu   = 1'b0;
    d.flash = 1'b0;
    case (m)
      M_ADCNR: d.io = 1'b0;
      M_PDOWN: begin
        d.io       = 1'b0;
        d.adc      = 1'b0;
        d.async_ck = 1'b0;
        d.osc      = 1'b0;
      end
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic [NSRC-1:0] wake_mask(input mode_e m);
    case (m)
      M_ADCNR: return 12'h3FF;
      M_PDOWN: return 12'h32E;
      default: return 12'hFFF;
    endcase
  endfunction

  function automatic int unsigned settle_cycles(input longint unsigned hz,
                                                input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

  function automatic bit adc_kick(input mode_e m, input logic on);
    return on && (m != M_PDOWN);
  endfunction

endpackage

// File: rtl/slp_ctl_reg.sv
module slp_ctl_reg #(
  parameter int WINDOW  = 4,
  parameter int OFF_POS = 6,
  parameter int ARM_POS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       bod_off_bit
);
  localparam int AW = $clog2(WINDOW + 1);

  logic [AW-1:0] arm_cnt;
  logic          arm_write;
  logic          load_write;

  assign arm_write  = wr_en && wdata[OFF_POS] && wdata[ARM_POS];
  assign load_write = wr_en && !wdata[ARM_POS] && (arm_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt     <= '0;
      bod_off_bit <= 1'b0;
    end else if (arm_write) begin
      arm_cnt <= AW'(WINDOW);
    end else if (load_write) begin
      bod_off_bit <= wdata[OFF_POS];
      arm_cnt     <= '0;
    end else if (arm_cnt != '0) begin
      arm_cnt <= arm_cnt - 1'b1;
    end
  end

  // R7: an open window shrinks by one on every edge without a write
  a_r7_window_count: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_cnt != '0 && !wr_en) |=> (arm_cnt == $past(arm_cnt) - 1'b1));

  // R7: the bit never moves without a write inside the window
  a_r7_bit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && arm_cnt != '0) |=> $stable(bod_off_bit));

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
  parameter int unsigned LONG_CYC  = 60,
  parameter int unsigned SHORT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic done
);
  localparam int unsigned MAXD = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
      busy <= 1'b1;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9: a running count always moves toward zero
  a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !start) |=> (busy && cnt == $past(cnt) - 1'b1));

  initial begin
    a_r9_nonzero_delay: assert (LONG_CYC >= 1 && SHORT_CYC >= 1);
  end

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic [2:0]      mode_sel,
  input  logic            adc_on,
  input  logic            bod_off_bit,
  input  logic [NSRC-1:0] wake_vec,
  input  logic            tmr_done,
  output logic            tmr_start,
  output logic            tmr_long,
  output dom_t            dom,
  output logic            bod_en,
  output logic            adc_start,
  output logic            cpu_run
);
  state_e st;
  mode_e  mode_q;
  logic   bod_off_q;

  mode_e  req_mode;
  logic   pend_req;
  logic   pend_sleep;
  logic   enter_ev;
  logic   wake_ev;
  logic   refuse_ev;

  assign req_mode   = decode_mode(mode_sel);
  assign pend_req   = |(wake_vec & wake_mask(req_mode));
  assign pend_sleep = |(wake_vec & wake_mask(mode_q));
  assign enter_ev   = (st == S_RUN) && sleep_req && !pend_req;
  assign refuse_ev  = (st == S_RUN) && sleep_req && pend_req;
  assign wake_ev    = (st == S_SLEEP) && pend_sleep;

  assign tmr_start = wake_ev;
  assign tmr_long  = bod_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      mode_q    <= M_IDLE;
      bod_off_q <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      case (st)
        S_RUN: if (enter_ev) begin
          st        <= S_SLEEP;
          mode_q    <= req_mode;
          bod_off_q <= bod_off_bit && (req_mode == M_PDOWN);
          adc_start <= adc_kick(req_mode, adc_on);
        end
        S_SLEEP: if (wake_ev) st <= S_WAKE;
        S_WAKE:  if (tmr_done) begin
          st        <= S_RUN;
          bod_off_q <= 1'b0;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_SLEEP: dom = gate_set(mode_q);
      S_WAKE:  dom = DOM_WAKE;
      default: dom = DOM_ALL;
    endcase
  end

  assign bod_en  = !((st == S_SLEEP) && bod_off_q);
  assign cpu_run = (st == S_RUN);

  // R2: no sleep state leaves the core clocked
  a_r2_core_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP) |-> (!dom.cpu && !dom.flash));

  // R4: power-down stops every domain
  a_r4_pd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && mode_q == M_PDOWN) |-> (dom == '0));

  // R6: start pulse lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R8: the detector is off only during sleep
  a_r8_bod_sleep_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bod_en |-> (st == S_SLEEP && mode_q == M_PDOWN));

  // R9: resume follows the end of the wake delay
  a_r9_resume_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAKE && !tmr_done) |=> !cpu_run);

  // R10: a refused request leaves the core running
  a_r10_refuse_stays: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_ev |=> (cpu_run && !adc_start));

  // R11: the latched mode holds while not running
  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |=> $stable(mode_q));

endmodule

// File: rtl/slp_pwr_ctl.sv
module slp_pwr_ctl #(
  parameter longint unsigned CLK_HZ     = 1000000,
  parameter int unsigned     SETTLE_US  = 60,
  parameter int unsigned     SHORT_WAKE = 4,
  parameter int              ARM_WINDOW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic [2:0]  mode_sel,
  input  logic        adc_on,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  input  logic [11:0] wake_vec,
  output logic        clk_en_cpu,
  output logic        clk_en_flash,
  output logic        clk_en_io,
  output logic        clk_en_adc,
  output logic        clk_en_async,
  output logic        osc_en,
  output logic        bod_en,
  output logic        adc_start,
  output logic        cpu_run
);
  import slp_pkg::*;

  localparam int unsigned LONG_WAKE = settle_cycles(CLK_HZ, longint'(SETTLE_US));

  logic bod_off_bit;
  logic tmr_start;
  logic tmr_long;
  logic tmr_busy;
  logic tmr_done;
  dom_t dom;

  slp_ctl_reg #(
    .WINDOW  (ARM_WINDOW),
    .OFF_POS (6),
    .ARM_POS (5)
  ) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ctl_wr),
    .wdata       (ctl_wdata),
    .bod_off_bit (bod_off_bit)
  );

  slp_wake_timer #(
    .LONG_CYC  (LONG_WAKE),
    .SHORT_CYC (SHORT_WAKE)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .long_sel (tmr_long),
    .busy     (tmr_busy),
    .done     (tmr_done)
  );

  slp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .mode_sel    (mode_sel),
    .adc_on      (adc_on),
    .bod_off_bit (bod_off_bit),
    .wake_vec    (wake_vec),
    .tmr_done    (tmr_done),
    .tmr_start   (tmr_start),
    .tmr_long    (tmr_long),
    .dom         (dom),
    .bod_en      (bod_en),
    .adc_start   (adc_start),
    .cpu_run     (cpu_run)
  );

  assign clk_en_cpu   = dom.cpu;
  assign clk_en_flash = dom.flash;
  assign clk_en_io    = dom.io;
  assign clk_en_adc   = dom.adc;
  assign clk_en_async = dom.async_ck;
  assign osc_en       = dom.osc;

  // R9: the delay timer only runs while the core is held
  a_r9_timer_holds_core: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !cpu_run);

endmodule

// File: tb/sim_slp_pwr_ctl.sv
module sim_slp_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LONG   = 60;   // 60 us at 1 MHz
  localparam int EXP_SHORT  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic [2:0]  mode_sel = 3'b000;
  logic        adc_on = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [11:0] wake_vec = 12'h000;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en;
  logic bod_en, adc_start, cpu_run;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slp_pwr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
    .adc_on(adc_on), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .wake_vec(wake_vec),
    .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
    .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_en(osc_en),
    .bod_en(bod_en), .adc_start(adc_start), .cpu_run(cpu_run)
  );

  // {cpu, flash, io, adc, async, osc}
  localparam logic [5:0] G_RUN   = 6'b111111;
  localparam logic [5:0] G_IDLE  = 6'b001111;
  localparam logic [5:0] G_ADCNR = 6'b000111;
  localparam logic [5:0] G_PD    = 6'b000000;
  localparam logic [5:0] G_WAKE  = 6'b001111;

  function automatic logic [5:0] gates();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic go_sleep(input logic [2:0] m);
    mode_sel = m; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  // raise one wake bit, count negedges until cpu_run
  task automatic wake_and_time(input int bitn, input int exp_d, input string req);
    int n;
    wake_vec[bitn] = 1'b1;
    n = 0;
    for (int i = 0; i < exp_d + 8; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        wake_vec = 12'h000;
        chk("R8", "bod_en in wake phase", bod_en, 1);
        chk("R9", "gating in wake phase", gates(), G_WAKE);
      end
      if (cpu_run) break;
    end
    chk(req, "wake delay edges", n - 1, exp_d);
  endtask

  task automatic t_reset();
    chk("R1", "gates after reset", gates(), G_RUN);
    chk("R1", "bod_en after reset", bod_en, 1);
    chk("R1", "cpu_run after reset", cpu_run, 1);
    chk("R1", "adc_start after reset", adc_start, 0);
    go_sleep(3'b010);
    chk("R1", "detector-off bit clear after reset", bod_en, 1);
    wake_and_time(1, EXP_SHORT, "R9");
  endtask

  task automatic t_idle(input logic [2:0] m);
    adc_on = 1'b1;
    go_sleep(m);
    chk("R2", "idle gating", gates(), G_IDLE);
    chk("R6", "adc_start on idle entry", adc_start, 1);
    chk("R2", "cpu_run idle", cpu_run, 0);
    step(1);
    chk("R6", "adc_start one cycle", adc_start, 0);
    adc_on = 1'b0;
    wake_and_time(11, EXP_SHORT, "R5");
  endtask

  task automatic t_adcnr();
    adc_on = 1'b0;
    go_sleep(3'b001);
    chk("R3", "adc-nr gating", gates(), G_ADCNR);
    chk("R6", "no adc_start when adc off", adc_start, 0);
    wake_vec[10] = 1'b1;
    step(3);
    wake_vec = 12'h000;
    chk("R5", "timer overflow ignored in adc-nr", cpu_run, 0);
    chk("R5", "gating held after ignored wake", gates(), G_ADCNR);
    mode_sel = 3'b010; sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
    step(1);
    chk("R11", "sleep_req ignored while asleep", gates(), G_ADCNR);
    wake_and_time(0, EXP_SHORT, "R5");
  endtask

  task automatic t_pdown_plain();
    adc_on = 1'b1;
    go_sleep(3'b010);
    chk("R4", "power-down gating", gates(), G_PD);
    chk("R6", "no adc_start in power-down", adc_start, 0);
    chk("R8", "bod_en with bit clear", bod_en, 1);
    wake_vec[0] = 1'b1;
    step(2);
    wake_vec = 12'h000;
    chk("R5", "adc done ignored in power-down", cpu_run, 0);
    adc_on = 1'b0;
    wake_and_time(9, EXP_SHORT, "R5");
  endtask

  task automatic t_window();
    // fifth edge after arming: too late
    ctl_write(8'h60);
    step(4);
    ctl_write(8'h40);
    go_sleep(3'b010);
    chk("R7", "late write ignored", bod_en, 1);
    wake_and_time(2, EXP_SHORT, "R9");
    // unarmed write
    ctl_write(8'h40);
    go_sleep(3'b010);
    chk("R7", "unarmed write ignored", bod_en, 1);
    wake_and_time(2, EXP_SHORT, "R9");
    // fourth edge: accepted
    ctl_write(8'h60);
    step(3);
    ctl_write(8'h40);
    go_sleep(3'b000);
    chk("R8", "bit set but idle keeps detector", bod_en, 1);
    wake_and_time(4, EXP_SHORT, "R9");
    go_sleep(3'b010);
    chk("R8", "detector off in power-down", bod_en, 0);
    wake_and_time(8, EXP_LONG, "R9");
    // unarmed clear must not clear
    ctl_write(8'h00);
    go_sleep(3'b010);
    chk("R7", "unarmed clear ignored", bod_en, 0);
    wake_and_time(3, EXP_LONG, "R9");
    // armed clear on next edge
    ctl_write(8'h60);
    ctl_write(8'h00);
    go_sleep(3'b010);
    chk("R7", "armed clear accepted", bod_en, 1);
    wake_and_time(3, EXP_SHORT, "R9");
  endtask

  task automatic t_pending();
    adc_on = 1'b1;
    wake_vec = 12'h800;  // bit 11 does not qualify for power-down
    go_sleep(3'b010);
    chk("R10", "non-qualifying pending still sleeps", cpu_run, 0);
    wake_vec = 12'h000;
    wake_and_time(5, EXP_SHORT, "R5");
    wake_vec = 12'h020;  // bit 5 qualifies
    go_sleep(3'b010);
    chk("R10", "refused: cpu_run", cpu_run, 1);
    chk("R10", "refused: gating", gates(), G_RUN);
    wake_vec = 12'h001;
    go_sleep(3'b001);
    chk("R10", "refused adc-nr: no adc_start", adc_start, 0);
    chk("R10", "refused adc-nr: gating", gates(), G_RUN);
    wake_vec = 12'h000;
    adc_on = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_idle(3'b000);
    t_idle(3'b101);
    t_adcnr();
    t_pdown_plain();
    t_window();
    t_pending();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule